// File: doc/BRIEF.md
# Registered PROM with Output Enables

This block is a 1024-word by 8-bit read-only memory whose read path ends in an edge-triggered pipeline register. On every rising clock edge the word selected by `addr` is captured, so the address may move on to the next location right after an edge while the previous word stays stable at the outputs. Real tri-state pins are replaced by a data bus `dout` and a drive flag `dout_drive`. While the flag is low, `dout` reads as zero.

Two enables decide whether the outputs are driven. A synchronous enable, `sync_en_n`, is sampled into a small two-state machine on each rising edge. In state `DRV_HOLD_OFF` the outputs are off. In state `DRV_ARMED` they may be driven. Reset puts the machine in `DRV_HOLD_OFF`. The transition `HOLD_OFF->ARMED` happens on an edge where `sync_en_n` is low, and `ARMED->HOLD_OFF` happens on an edge where it is high. Otherwise each state holds itself. An asynchronous enable, `async_en_n`, gates the drive at once without a clock. The outputs are driven only in `DRV_ARMED` with `async_en_n` low.

An active-low asynchronous input, `load_init_n`, loads a separate programmable initialize word into the pipeline register at once and holds it there while it stays low. A programming port writes the array words and the initialize word. It is accepted only in `DRV_HOLD_OFF`. All contents are zero after reset.

Top module: `regd_prom`

## Requirements
- R1: After reset `dout_drive` is 0 and `dout` is 0, and every array word and the initialize word read as zero. Whenever `dout_drive` is 0, `dout` is 0.
- R2: On each rising edge with `load_init_n` high, the register captures the array word at `addr`. This word appears on `dout` after that edge when the outputs are driven.
- R3: A change of `addr` between rising edges leaves `dout` unchanged until the next rising edge.
- R4: If `sync_en_n` is sampled high at a rising edge, `dout_drive` is 0 after that edge, whatever the level of `async_en_n`.
- R5: If `sync_en_n` is sampled low at a rising edge, `dout_drive` is 1 after that edge while `async_en_n` is low.
- R6: `async_en_n` high forces `dout_drive` to 0 without a clock. Returning it low restores the drive at once in state `DRV_ARMED`.
- R7: A falling `load_init_n` loads the initialize word into the register immediately, without a clock edge.
- R8: While `load_init_n` stays low, rising edges keep the initialize word in the register instead of an array word.
- R9: An initialize word of 8'h00 clears the register. One of 8'hFF presets it.
- R10: The initialize word reaches `dout` only when both enable conditions allow driving.
- R11: On a rising edge with `prog_we` high in state `DRV_HOLD_OFF`, `prog_data` is written to the initialize word when `prog_sel_init` is 1, and to array word `prog_addr` when it is 0. In state `DRV_ARMED` the write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| addr | input | 10 | Read address |
| sync_en_n | input | 1 | Active-low synchronous output enable, sampled on the clock |
| async_en_n | input | 1 | Active-low asynchronous output enable |
| load_init_n | input | 1 | Active-low asynchronous initialize-word load |
| prog_we | input | 1 | Programming write strobe |
| prog_sel_init | input | 1 | 1 selects the initialize word, 0 selects an array word |
| prog_addr | input | 10 | Programming address |
| prog_data | input | 8 | Programming data |
| dout | output | 8 | Register contents when driven, zero otherwise |
| dout_drive | output | 1 | High when the outputs are driven |

## Verification
A held initialize and a clocked load can fall on the same rising edge. The bench keeps `load_init_n` low across edges while `addr` points at a non-zero word and `sync_en_n` arms the outputs. It then expects the initialize word rather than the array word. The asynchronous enable and the initialize load are also changed together between edges. The bench judges the result against its behavioural model immediately after each asynchronous change and again after every rising edge.

// File: rtl/regd_prom_pkg.sv
package regd_prom_pkg;
    localparam int PROM_ADDR_W = 10;
    localparam int PROM_DATA_W = 8;

    typedef enum logic [0:0] {
        DRV_HOLD_OFF = 1'b0,
        DRV_ARMED    = 1'b1
    } drv_state_e;
endpackage

// File: rtl/regd_prom_array.sv
module regd_prom_array #(
    parameter int ADDR_W = regd_prom_pkg::PROM_ADDR_W,
    parameter int DATA_W = regd_prom_pkg::PROM_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel_init,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] init_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];
    logic [DATA_W-1:0] init_q;

    // array words and the extra initialize word, all blank after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
            init_q <= '0;
        end else if (wr_en) begin
            if (wr_sel_init) begin
                init_q <= wr_data;
            end else begin
                words[wr_addr] <= wr_data;
            end
        end
    end

    assign rd_word   = words[rd_addr];
    assign init_word = init_q;
endmodule

// File: rtl/regd_prom_pipe.sv
module regd_prom_pipe #(
    parameter int DATA_W = regd_prom_pkg::PROM_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_init_n,
    input  logic [DATA_W-1:0] d,
    input  logic [DATA_W-1:0] init_word,
    output logic [DATA_W-1:0] q
);
    // the initialize load overrides the clock for as long as it is held
    always_ff @(posedge clk or negedge rst_n or negedge load_init_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (!load_init_n) begin
            q <= init_word;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/regd_prom_drive_fsm.sv
module regd_prom_drive_fsm
    import regd_prom_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_en_n,
    input  logic async_en_n,
    output logic armed,
    output logic drive
);
    drv_state_e state_q;
    drv_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DRV_HOLD_OFF: if (!sync_en_n) state_d = DRV_ARMED;
            DRV_ARMED:    if (sync_en_n)  state_d = DRV_HOLD_OFF;
            default:      state_d = DRV_HOLD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DRV_HOLD_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        armed = 1'b0;
        drive = 1'b0;
        unique case (state_q)
            DRV_HOLD_OFF: begin
                armed = 1'b0;
                drive = 1'b0;
            end
            DRV_ARMED: begin
                armed = 1'b1;
                drive = !async_en_n;
            end
            default: begin
                armed = 1'b0;
                drive = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/regd_prom.sv
module regd_prom #(
    parameter int ADDR_W = regd_prom_pkg::PROM_ADDR_W,
    parameter int DATA_W = regd_prom_pkg::PROM_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sync_en_n,
    input  logic              async_en_n,
    input  logic              load_init_n,
    input  logic              prog_we,
    input  logic              prog_sel_init,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_drive
);
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] init_q;
    logic [DATA_W-1:0] pipe_q;
    logic              armed;
    logic              drive;
    logic              prog_ok;

    // programming only while the outputs are held off
    assign prog_ok = prog_we && !armed;

    regd_prom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (prog_ok),
        .wr_sel_init (prog_sel_init),
        .wr_addr     (prog_addr),
        .wr_data     (prog_data),
        .rd_addr     (addr),
        .rd_word     (rd_word),
        .init_word   (init_q)
    );

    regd_prom_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_init_n (load_init_n),
        .d           (rd_word),
        .init_word   (init_q),
        .q           (pipe_q)
    );

    regd_prom_drive_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_en_n  (sync_en_n),
        .async_en_n (async_en_n),
        .armed      (armed),
        .drive      (drive)
    );

    assign dout_drive = drive;
    assign dout       = drive ? pipe_q : '0;
endmodule

// File: rtl/regd_prom_chk.sv
module regd_prom_chk #(
    parameter int DATA_W = regd_prom_pkg::PROM_DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_en_n,
    input logic              async_en_n,
    input logic              load_init_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_drive,
    input logic [DATA_W-1:0] pipe_q,
    input logic [DATA_W-1:0] init_q
);
    // R1
    undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_drive |-> (dout == '0));

    // R4
    sync_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_en_n |=> !dout_drive);

    // R5
    sync_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_en_n && !async_en_n) |=> (dout_drive || async_en_n));

    // R6
    async_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        async_en_n |-> !dout_drive);

    // R8
    init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_init_n |=> (pipe_q == $past(init_q)));
endmodule

bind regd_prom regd_prom_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_en_n   (sync_en_n),
    .async_en_n  (async_en_n),
    .load_init_n (load_init_n),
    .dout        (dout),
    .dout_drive  (dout_drive),
    .pipe_q      (pipe_q),
    .init_q      (init_q)
);

// File: tb/regd_prom_test.sv
`timescale 1ns/1ps
module regd_prom_test;
    localparam int AW = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          sync_en_n = 1'b1;
    logic          async_en_n = 1'b0;
    logic          load_init_n = 1'b1;
    logic          prog_we = 1'b0;
    logic          prog_sel_init = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [DW-1:0] prog_data = '0;
    logic [DW-1:0] dout;
    logic          dout_drive;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    bit    live = 0;
    string tag = "R1";

    // behavioural reference
    logic [DW-1:0] m_arr [1024];
    logic [DW-1:0] m_init;
    logic [DW-1:0] m_reg;
    bit            m_on;

    regd_prom uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sync_en_n(sync_en_n),
        .async_en_n(async_en_n), .load_init_n(load_init_n), .prog_we(prog_we),
        .prog_sel_init(prog_sel_init), .prog_addr(prog_addr), .prog_data(prog_data),
        .dout(dout), .dout_drive(dout_drive)
    );

    always #2.5 clk = ~clk;

    task automatic compare(input string req);
        logic          exp_drv;
        logic [DW-1:0] exp_out;
        exp_drv = m_on && !async_en_n;
        exp_out = exp_drv ? m_reg : '0;
        checks++;
        if (dout_drive !== exp_drv || dout !== exp_out) begin
            errors++;
            $display("FAIL %s: drive=%0b dout=%02h expected drive=%0b dout=%02h",
                     req, dout_drive, dout, exp_drv, exp_out);
        end
    endtask

    always @(posedge clk) begin
        logic [DW-1:0] nxt;
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) m_arr[i] = '0;
            m_init = '0;
            m_reg  = '0;
            m_on   = 0;
        end else begin
            nxt = load_init_n ? m_arr[addr] : m_init;
            if (prog_we && !m_on) begin
                if (prog_sel_init) m_init = prog_data;
                else m_arr[prog_addr] = prog_data;
            end
            m_on  = !sync_en_n;
            m_reg = nxt;
        end
        #1;
        if (live) compare(tag);
    end

    always @(negedge load_init_n) if (rst_n) m_reg = m_init;

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        compare("R1");
        live = 1;
        // R1 array blank: arm and read an unwritten word
        tag = "R1"; sync_en_n = 1'b0; addr = 10'd700;
        cyc(3);
        sync_en_n = 1'b1;
        cyc(2);
        // R11 program array words in hold-off state
        tag = "R11";
        for (int i = 0; i < 16; i++) begin
            prog_we = 1'b1; prog_sel_init = 1'b0;
            prog_addr = AW'(i); prog_data = DW'(i * 37 + 11);
            cyc(1);
        end
        prog_addr = 10'd1023; prog_data = 8'hA5;
        cyc(1);
        prog_we = 1'b0;
        // R9 blank initialize word clears
        load_init_n = 1'b0; #1 compare("R9");
        cyc(1); load_init_n = 1'b1;
        // R2 sequential reads
        tag = "R2"; sync_en_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            addr = AW'(i); cyc(1);
        end
        addr = 10'd1023; cyc(2);
        // R3 address moves mid-cycle
        addr = 10'd4;
        @(posedge clk); #1.5;
        addr = 10'd9; #0.5 compare("R3");
        cyc(2);
        // R6 asynchronous enable
        async_en_n = 1'b1; #1 compare("R6");
        cyc(1);
        async_en_n = 1'b0; #1 compare("R6");
        // R11 write ignored while armed
        tag = "R11";
        prog_we = 1'b1; prog_addr = 10'd3; prog_data = 8'hFF;
        cyc(1);
        prog_we = 1'b0; addr = 10'd3;
        cyc(2);
        // R4 sync enable high turns off despite async low
        tag = "R4"; sync_en_n = 1'b1;
        cyc(2);
        // R5 arm with async high, then release async
        tag = "R5"; sync_en_n = 1'b0; async_en_n = 1'b1;
        cyc(1);
        async_en_n = 1'b0; #1 compare("R5");
        cyc(1);
        // program initialize word to all ones
        sync_en_n = 1'b1; cyc(1);
        tag = "R11"; prog_we = 1'b1; prog_sel_init = 1'b1; prog_data = 8'hFF;
        cyc(1);
        prog_we = 1'b0; prog_sel_init = 1'b0;
        // R10 initialize hidden while held off
        load_init_n = 1'b0; #1 compare("R10");
        // R8 and R9 preset held across arming edges
        tag = "R8"; sync_en_n = 1'b0; addr = 10'd7;
        cyc(3);
        load_init_n = 1'b1;
        tag = "R2"; cyc(2);
        // R7 immediate load while driven
        load_init_n = 1'b0; #1 compare("R7");
        cyc(1); load_init_n = 1'b1;
        cyc(1);
        // R10 async enable and initialize together
        async_en_n = 1'b1; load_init_n = 1'b0; #1 compare("R10");
        async_en_n = 1'b0; #1 compare("R10");
        cyc(1); load_init_n = 1'b1;
        cyc(2);
        live = 0;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule